// File: doc/BRIEF.md
# Divisor-Paced Serial Transmit Engine

This block turns one parallel data word at a time into an asynchronous serial frame. The frame has a low start bit, the data bits with the least significant bit first, and a high stop bit. A host-side holding register sits in front of the block. It presents a word and raises a ready level. The engine copies the word into its own shift register and answers with a one-cycle taken pulse, so the host can mark its holding register free again and load the next word while the current frame is still on the line.

Bit timing comes from a prescaler whose span is the runtime divisor times a fixed oversampling factor, which defaults to 16. A reload strobe restarts the prescaler count whenever software rewrites the divisor. An empty level reports whether the shift register holds a frame. The host ANDs this level with its own holding-register flag to form a transmitter-empty status.

Top module: `uart_tx_engine`

## Requirements
- R1: Every bit of a frame, including start and stop, stays on `txd` for exactly OVERSAMPLE × `divisor` clock cycles (16 × `divisor` by default).
- R2: A frame is a start bit of 0, then DATA_W data bits with bit 0 first, then one stop bit of 1; `txd` is 1 whenever no frame is in progress.
- R3: When the engine is idle, `word_ready` is 1 and `divisor` is non-zero at a clock edge, the engine takes `tx_word`, and the start bit appears on `txd` in the cycle that follows that edge.
- R4: `word_taken` is high for exactly one clock cycle per accepted word. It coincides with the first cycle of that word's start bit.
- R5: `shift_empty` goes low in the cycle the word is taken and returns high only after the stop bit of the last queued word has lasted its full bit period.
- R6: If `word_ready` is 1 when a stop bit ends, the next word is taken at that edge. Its start bit follows the stop bit with no idle cycle, and `shift_empty` stays low between the two frames.
- R7: Changes on `tx_word` after a word has been taken have no effect on the frame being sent.
- R8: A one-cycle `div_reload` pulse restarts the current bit's count from zero, using the divisor value present at that time.
- R9: While `rst` is high, `txd` is 1, `shift_empty` is 1, `word_taken` is 0, and the prescaler and bit position clear.
- R10: With `divisor` at 0, an idle engine starts no frame, gives no taken pulse and keeps `txd` at 1. A word still pending when the divisor becomes non-zero is then taken normally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_word | input | DATA_W | Word presented by the holding register |
| word_ready | input | 1 | Holding register contains a word not yet taken |
| divisor | input | DIV_W | Bit period in units of OVERSAMPLE clock cycles |
| div_reload | input | 1 | Pulse: divisor rewritten, restart prescaler count |
| txd | output | 1 | Serial line, idle high |
| word_taken | output | 1 | One-cycle pulse when a word enters the shift register |
| shift_empty | output | 1 | High while no frame is in the shift register |

## Verification
The bench builds the block with its default parameters: 8-bit words, a 16-bit divisor and 16× oversampling. It then drives divisor values of 0 to 3, so a full frame lasts at most 480 cycles. At these small divisors the bench can, within a short run, cover back-to-back frames, a data change during a frame, a reload in the middle of a bit, and a word that waits on a zero divisor and starts once the divisor becomes non-zero. On every clock a behavioural model, built from counters and a bit queue, predicts all three outputs.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_SEND = 1'b1
   } tx_state_e;

   // Index of the stop bit inside a frame (start bit is index 0).
   function automatic int unsigned stop_index(input int unsigned data_w);
      return data_w + 1;
   endfunction

endpackage

// File: rtl/uart_tx_prescaler.sv
module uart_tx_prescaler #(
   parameter int unsigned DIV_W      = 16,
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [DIV_W-1:0] divisor,
   input  logic             restart,
   output logic             bit_tick
);

   localparam int unsigned OS_SH = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 0;
   localparam int unsigned CNT_W = DIV_W + OS_SH + 1;
   localparam bit OS_POW2 = ((1 << OS_SH) == OVERSAMPLE);

   logic [CNT_W-1:0] span;
   logic [CNT_W-1:0] count_q;

   generate
      if (OS_POW2) begin : g_shift_span
         assign span = CNT_W'(divisor) << OS_SH;
      end else begin : g_mult_span
         assign span = CNT_W'(divisor) * CNT_W'(OVERSAMPLE);
      end
   endgenerate

   // A zero span never ticks; a count left above a shrunken span ends at once.
   assign bit_tick = (span != '0) && (count_q >= (span - 1'b1));

   always_ff @(posedge clk) begin
      if (rst || restart || bit_tick) begin
         count_q <= '0;
      end else begin
         count_q <= count_q + 1'b1;
      end
   end

endmodule

// File: rtl/uart_tx_sequencer.sv
module uart_tx_sequencer
   import uart_tx_pkg::*;
#(
   parameter int unsigned DATA_W = 8
) (
   input  logic clk,
   input  logic rst,
   input  logic bit_tick,
   input  logic word_ready,
   input  logic div_nonzero,
   output logic take,
   output logic advance,
   output logic busy
);

   localparam int unsigned LAST   = stop_index(DATA_W);
   localparam int unsigned IDX_W  = $clog2(LAST + 1);

   tx_state_e            state_q;
   logic [IDX_W-1:0]     idx_q;
   logic                 at_stop;

   assign at_stop = (idx_q == IDX_W'(LAST));
   assign busy    = (state_q == TX_SEND);

   always_comb begin
      take    = 1'b0;
      advance = 1'b0;
      if (state_q == TX_IDLE) begin
         take = word_ready && div_nonzero;
      end else if (bit_tick) begin
         if (at_stop) begin
            take = word_ready;
         end else begin
            advance = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= TX_IDLE;
         idx_q   <= '0;
      end else if (take) begin
         state_q <= TX_SEND;
         idx_q   <= '0;
      end else if (advance) begin
         idx_q   <= idx_q + 1'b1;
      end else if (busy && bit_tick && at_stop) begin
         state_q <= TX_IDLE;
         idx_q   <= '0;
      end
   end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load,
   input  logic [DATA_W-1:0] load_word,
   input  logic              advance,
   output logic              txd
);

   logic [DATA_W-1:0] shreg_q;

   // Ones are shifted in behind the data, so the bit after the last data bit is the stop level.
   always_ff @(posedge clk) begin
      if (rst) begin
         shreg_q <= '1;
         txd     <= 1'b1;
      end else if (load) begin
         shreg_q <= load_word;
         txd     <= 1'b0;
      end else if (advance) begin
         shreg_q <= {1'b1, shreg_q[DATA_W-1:1]};
         txd     <= shreg_q[0];
      end
   end

endmodule

// File: rtl/uart_tx_engine.sv
module uart_tx_engine #(
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned DIV_W      = 16,
   parameter int unsigned OVERSAMPLE = 16
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [DATA_W-1:0] tx_word,
   input  logic              word_ready,
   input  logic [DIV_W-1:0]  divisor,
   input  logic              div_reload,
   output logic              txd,
   output logic              word_taken,
   output logic              shift_empty
);

   initial begin
      if (DATA_W < 1)     $error("DATA_W must be at least 1");
      if (DIV_W < 1)      $error("DIV_W must be at least 1");
      if (OVERSAMPLE < 1) $error("OVERSAMPLE must be at least 1");
   end

   logic bit_tick;
   logic take;
   logic advance;
   logic busy;
   logic taken_q;

   uart_tx_prescaler #(
      .DIV_W      (DIV_W),
      .OVERSAMPLE (OVERSAMPLE)
   ) prescale_i (
      .clk      (clk),
      .rst      (rst),
      .divisor  (divisor),
      .restart  (take || div_reload),
      .bit_tick (bit_tick)
   );

   uart_tx_sequencer #(
      .DATA_W (DATA_W)
   ) seq_i (
      .clk         (clk),
      .rst         (rst),
      .bit_tick    (bit_tick),
      .word_ready  (word_ready),
      .div_nonzero (divisor != '0),
      .take        (take),
      .advance     (advance),
      .busy        (busy)
   );

   uart_tx_shifter #(
      .DATA_W (DATA_W)
   ) shift_i (
      .clk       (clk),
      .rst       (rst),
      .load      (take),
      .load_word (tx_word),
      .advance   (advance),
      .txd       (txd)
   );

   always_ff @(posedge clk) begin
      if (rst) taken_q <= 1'b0;
      else     taken_q <= take;
   end

   assign word_taken  = taken_q;
   assign shift_empty = !busy;

endmodule

// File: rtl/uart_tx_engine_chk.sv
module uart_tx_engine_chk #(
   parameter int unsigned DIV_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic [DIV_W-1:0] divisor,
   input logic             txd,
   input logic             word_taken,
   input logic             shift_empty
);

   // R4
   taken_single_chk: assert property (@(posedge clk) disable iff (rst)
      word_taken |=> !word_taken);

   // R5
   empty_low_on_take_chk: assert property (@(posedge clk) disable iff (rst)
      word_taken |-> !shift_empty);

   // R2
   idle_line_high_chk: assert property (@(posedge clk) disable iff (rst)
      shift_empty |-> txd);

   // R3
   start_bit_with_take_chk: assert property (@(posedge clk) disable iff (rst)
      word_taken |-> !txd);

   // R10
   zero_div_no_take_chk: assert property (@(posedge clk) disable iff (rst)
      (shift_empty && divisor == '0) |=> !word_taken);

endmodule

bind uart_tx_engine uart_tx_engine_chk #(.DIV_W(DIV_W)) chk_i (
   .clk         (clk),
   .rst         (rst),
   .divisor     (divisor),
   .txd         (txd),
   .word_taken  (word_taken),
   .shift_empty (shift_empty)
);

// File: tb/uart_tx_engine_tb_top.sv
module uart_tx_engine_tb_top;

   localparam int DATA_W = 8;
   localparam int DIV_W  = 16;
   localparam int OS     = 16;
   localparam int WRAP   = 1 << (DIV_W + 5);

   logic              clk = 1'b0;
   logic              rst = 1'b1;
   logic [DATA_W-1:0] tx_word = '0;
   logic              word_ready = 1'b0;
   logic [DIV_W-1:0]  divisor = 16'd1;
   logic              div_reload = 1'b0;
   logic              txd;
   logic              word_taken;
   logic              shift_empty;

   always #10 clk = ~clk;

   uart_tx_engine #(.DATA_W(DATA_W), .DIV_W(DIV_W), .OVERSAMPLE(OS)) dut_i (
      .clk (clk), .rst (rst), .tx_word (tx_word), .word_ready (word_ready),
      .divisor (divisor), .div_reload (div_reload), .txd (txd),
      .word_taken (word_taken), .shift_empty (shift_empty)
   );

   // Behavioural reference: busy flag, bit position, elapsed cycles, queue of line levels.
   int  m_busy = 0, m_pos = 0, m_elapsed = 0;
   bit  m_txd = 1, m_taken = 0;
   bit  m_bits[$];
   int  vectors = 0, fails = 0, cycles = 0;
   string tag = "R9";

   always @(posedge clk) begin
      int  period;
      bit  tick, take;
      if (rst) begin
         m_busy = 0; m_pos = 0; m_elapsed = 0; m_txd = 1; m_taken = 0;
         m_bits.delete();
      end else begin
         period = OS * int'(divisor);
         tick   = (period != 0) && (m_elapsed >= period - 1);
         take   = (m_busy == 0) ? (word_ready && divisor != 0)
                                : (tick && m_pos == DATA_W + 1 && word_ready);
         m_taken = take;
         if (take) begin
            m_bits.delete();
            for (int i = 0; i < DATA_W; i++) m_bits.push_back(tx_word[i]);
            m_bits.push_back(1'b1);
            m_busy = 1; m_pos = 0; m_txd = 0;
         end else if (m_busy != 0 && tick) begin
            if (m_pos == DATA_W + 1) begin
               m_busy = 0; m_txd = 1;
            end else begin
               m_pos++;
               m_txd = m_bits.pop_front();
            end
         end
         if (take || div_reload || tick) m_elapsed = 0;
         else m_elapsed = (m_elapsed + 1) % WRAP;
      end
   end

   // Compare on every falling edge (R1 R2 timing, R3 R4 pulse, R5 R6 empty).
   always @(negedge clk) begin
      bit bad;
      if (!rst) begin
         bad = 0;
         vectors++;
         if (txd !== m_txd) begin
            bad = 1;
            $display("FAIL %s/R2 txd: actual %b expected %b at cycle %0d", tag, txd, m_txd, cycles);
         end
         if (word_taken !== m_taken) begin
            bad = 1;
            $display("FAIL %s/R4 word_taken: actual %b expected %b at cycle %0d", tag, word_taken, m_taken, cycles);
         end
         if (shift_empty !== (m_busy == 0)) begin
            bad = 1;
            $display("FAIL %s/R5 shift_empty: actual %b expected %b at cycle %0d", tag, shift_empty, m_busy == 0, cycles);
         end
         if (bad) fails++;
      end
      cycles++;
      if (cycles > 150000) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

   task automatic write_word(input logic [DATA_W-1:0] w);
      @(negedge clk);
      tx_word = w;
      word_ready = 1'b1;
      while (word_taken !== 1'b1) @(negedge clk);
      word_ready = 1'b0;
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while (shift_empty !== 1'b1 && n < 5000) begin
         @(negedge clk);
         n++;
      end
      repeat (20) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: outputs during reset
      vectors++;
      if (txd !== 1'b1 || word_taken !== 1'b0 || shift_empty !== 1'b1) begin
         fails++;
         $display("FAIL R9 reset: actual txd=%b taken=%b empty=%b expected 1 0 1", txd, word_taken, shift_empty);
      end
      rst = 1'b0;
      repeat (5) @(negedge clk);

      // R1 R2 R3: single frame, divisor 1
      tag = "R3";
      write_word(8'h4B);
      wait_idle();

      // R6 R7: second word queued during a frame, input changed after take
      tag = "R6";
      divisor = 16'd2;
      write_word(8'hB1);
      tx_word = 8'h00;
      repeat (7) @(negedge clk);
      tag = "R7";
      tx_word = 8'hFF;
      write_word(8'h5A);
      tx_word = 8'hC3;
      wait_idle();

      // R8: reload in the middle of a bit, also with a new divisor value
      tag = "R8";
      divisor = 16'd3;
      write_word(8'h96);
      repeat (30) @(negedge clk);
      div_reload = 1'b1;
      @(negedge clk);
      div_reload = 1'b0;
      repeat (60) @(negedge clk);
      divisor = 16'd1;
      div_reload = 1'b1;
      @(negedge clk);
      div_reload = 1'b0;
      wait_idle();

      // R10: zero divisor leaves the engine idle, pending word starts later
      tag = "R10";
      divisor = 16'd0;
      @(negedge clk);
      tx_word = 8'h3C;
      word_ready = 1'b1;
      repeat (200) @(negedge clk);
      vectors++;
      if (word_taken !== 1'b0 || txd !== 1'b1 || shift_empty !== 1'b1) begin
         fails++;
         $display("FAIL R10 zero divisor: actual txd=%b taken=%b empty=%b expected 1 0 1", txd, word_taken, shift_empty);
      end
      divisor = 16'd1;
      while (word_taken !== 1'b1) @(negedge clk);
      word_ready = 1'b0;
      wait_idle();

      // R1: another pattern at divisor 2, all-ones and all-zeros words back to back
      tag = "R1";
      divisor = 16'd2;
      write_word(8'hFF);
      write_word(8'h00);
      wait_idle();

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

endmodule